// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Periodic Interrupt

This block keeps wall-clock time as a packed-BCD calendar: seconds, minutes, hours, day of month, month, two-digit year and a day-of-week counter. A one-pulse-per-second input advances it. Software reaches it over a byte-wide register port with an address, a write strobe and a combinational read-data path. Through that port it sets the time while the clock is halted, starts and stops counting, and takes a coherent snapshot of the running time. The snapshot lands in shadow latches, and all later reads of the time registers come from those latches.

An alarm comparator watches the calendar after every counted second and raises a sticky flag when all six date/time fields equal the programmed alarm. Separate sticky flags record second, minute, hour and day rollovers. All flags clear when software writes a one to them. A single level interrupt combines the alarm flag with one selectable periodic flag under two enable bits.

Top module: `bcd_alarm_clock`

## Requirements
- R1: After reset the control register reads 0x00 (halted), interrupt enable reads 0x00, status reads 0x80 (power-up flag in bit 7), irq is low, and the time registers read seconds 00, minutes 00, hours 00, day 01, month 01, year 00, week 00.
- R2: While the run bit (control bit 0) is 1, each tick advances seconds in BCD. Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and carry into day and into week (0 to 6, wrapping to 0). Month wraps 12 to 01 and carries into year, which wraps 99 to 00.
- R3: Day wraps to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, after 30 in months 4, 6, 9 and 11, and in month 2 after 29 when the year is divisible by 4, otherwise after 28.
- R4: While the run bit is 0, ticks are ignored and writes to addresses 0x00 to 0x06 load the live counters. A value is loaded only if it is valid BCD inside the field's range. While running, those writes have no effect.
- R5: Writing the control register (0x0D) with bit 6 set copies the live counters into the shadow latches, and reads of 0x00 to 0x06 return the shadow latches. Control bit 6 reads back 0, while bits 0 and 3 read back as written.
- R6: On a counted tick, status bit 2 is set. Bit 3 is set when seconds wrap, bit 4 when minutes wrap and bit 5 when hours wrap. Status bit 1 reads the run bit.
- R7: Writing 1 to status bits 2 to 7 (address 0x0E) clears those flags, and writing 0 leaves them unchanged. A flag being set in the same cycle takes precedence.
- R8: Alarm registers 0x07 to 0x0C (seconds to year) are writable and readable at any time. Status bit 6 is set when, on a counted tick, the updated seconds, minutes, hours, day, month and year all equal them.
- R9: In the interrupt-enable register (0x0F), bits 1:0 select the periodic flag (0 second, 1 minute, 2 hour, 3 day), bit 2 enables it and bit 3 enables the alarm flag. irq is high exactly while an enabled flag is set.
- R10: Reads of any address above 0x0F return 0x00, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 5-bit address and a tick taken as a ready-made one-cycle pulse (TICK_EDGE = 0). The edge-detecting tick variant is therefore only elaborated. With the compact address, directed loads reach every year-end, month-end and February boundary in a few ticks. Random calendars with alarms placed a few seconds ahead make the six-field match and the periodic selector reachable within a hundred-odd ticks per trial.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;

   localparam int NFLD = 7;
   localparam int NALM = 6;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;
   localparam int F_WEEK = 6;

   localparam int A_ALM0 = 7;
   localparam int A_ALMN = 12;
   localparam int A_CTRL = 13;
   localparam int A_STAT = 14;
   localparam int A_IEN  = 15;

   localparam int CB_RUN  = 0;
   localparam int CB_H12  = 3;
   localparam int CB_SNAP = 6;

   function automatic logic [7:0] fld_lo(int i);
      return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] fld_max(int i);
      case (i)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_DAY:        return 8'h31;
         F_MON:        return 8'h12;
         F_YEAR:       return 8'h99;
         default:      return 8'h06;
      endcase
   endfunction

   function automatic logic [7:0] bcd_inc(logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // tens*10 mod 4 equals (tens mod 2)*2, so a 2-bit sum gives year mod 4
   function automatic logic [7:0] last_day(logic [7:0] mon, logic [7:0] yr);
      logic [1:0] r;
      r = {yr[4], 1'b0} + yr[1:0];
      case (mon)
         8'h02:                     return (r == 2'd0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                   return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_clk_field.sv
module bcd_clk_field #(
   parameter logic [7:0] LO   = 8'h00,
   parameter logic [7:0] MAXV = 8'h59,
   parameter logic [7:0] RST  = LO
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic [7:0] hi,
   output logic [7:0] cur,
   output logic [7:0] nxt,
   output logic       at_hi
);
   import bcd_clk_pkg::*;

   if (RST < LO || RST > MAXV || MAXV[3:0] > 4'd9) begin : g_bad_param
      $error("bcd_clk_field: reset value outside range or bad BCD limit");
   end

   logic load_ok;

   assign load_ok = load && (load_val[3:0] <= 4'd9) &&
                    (load_val >= LO) && (load_val <= MAXV);
   assign at_hi   = (cur >= hi);

   always_comb begin
      if (load_ok)   nxt = load_val;
      else if (step) nxt = at_hi ? LO : bcd_inc(cur);
      else           nxt = cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= RST;
      else        cur <= nxt;
   end

   assert_field_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur[3:0] <= 4'd9) && (cur >= LO) && (cur <= MAXV));

   assert_no_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cur));

endmodule

// File: rtl/bcd_clk_alarm.sv
module bcd_clk_alarm #(
   parameter int N = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2:0]          idx,
   input  logic [7:0]          wdata,
   input  logic                step,
   input  logic [N-1:0][7:0]   nxt,
   output logic [N-1:0][7:0]   alm,
   output logic                hit
);
   localparam int IDX_W = $clog2(N);

   if (N < 1 || IDX_W > 3) begin : g_bad_param
      $error("bcd_clk_alarm: field count out of range");
   end

   logic [N-1:0] eq;

   for (genvar i = 0; i < N; i++) begin : g_fld
      assign eq[i] = (nxt[i] == alm[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        alm[i] <= 8'h00;
         else if (we && idx == 3'(i))       alm[i] <= wdata;
      end
   end

   assign hit = step && (&eq);

   assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(alm));

endmodule

// File: rtl/bcd_clk_status.sv
module bcd_clk_status #(
   parameter int SEL_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [EVN-1:0]     ev_set,
   input  logic               alarm_set,
   input  logic               clr_en,
   input  logic [5:0]         clr_mask,
   input  logic [SEL_W+1:0]   ien,
   output logic [7:0]         status,
   output logic               irq
);
   localparam int EVN = 1 << SEL_W;

   if (EVN != 4) begin : g_bad_param
      $error("bcd_clk_status: the status byte holds exactly four periodic flags");
   end

   logic [EVN-1:0] ev_q;
   logic           alm_q;
   logic           pwr_q;
   logic [EVN-1:0] ev_clr;

   assign ev_clr = clr_en ? clr_mask[EVN-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q  <= '0;
         alm_q <= 1'b0;
         pwr_q <= 1'b1;
      end else begin
         ev_q  <= (ev_q & ~ev_clr) | ev_set;
         alm_q <= alarm_set | (alm_q & ~(clr_en & clr_mask[4]));
         pwr_q <= pwr_q & ~(clr_en & clr_mask[5]);
      end
   end

   assign status = {pwr_q, alm_q, ev_q, run, 1'b0};
   assign irq    = (ien[SEL_W+1] & alm_q) | (ien[SEL_W] & ev_q[ien[SEL_W-1:0]]);

   assert_alarm_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_q) |-> $past(alarm_set));

   assert_alarm_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alm_q) |-> $past(clr_en && clr_mask[4]));

   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (alm_q || ev_q != '0));

endmodule

// File: rtl/bcd_alarm_clock.sv
module bcd_alarm_clock #(
   parameter int ADDR_W    = 5,
   parameter bit TICK_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   output logic [7:0]        bus_rdata,
   output logic              irq
);
   import bcd_clk_pkg::*;

   localparam logic [ADDR_W-1:0] AD_ALM0 = ADDR_W'(A_ALM0);
   localparam logic [ADDR_W-1:0] AD_ALMN = ADDR_W'(A_ALMN);
   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
   localparam logic [ADDR_W-1:0] AD_TEND = ADDR_W'(NFLD);

   if (ADDR_W < 5) begin : g_bad_param
      $error("bcd_alarm_clock: address must be at least 5 bits wide");
   end

   // ---------------- tick qualification ----------------
   logic tick_p;
   if (TICK_EDGE) begin : g_edge
      logic tick_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_d <= 1'b0;
         else        tick_d <= tick_in;
      end
      assign tick_p = tick_in & ~tick_d;
   end else begin : g_pulse
      assign tick_p = tick_in;
   end

   // ---------------- control and enable ----------------
   logic       run_q, h12_q;
   logic [3:0] ien_q;
   logic       wr_ctrl, wr_stat, wr_ien, wr_alm, snap;

   assign wr_ctrl = bus_we && bus_addr == AD_CTRL;
   assign wr_stat = bus_we && bus_addr == AD_STAT;
   assign wr_ien  = bus_we && bus_addr == AD_IEN;
   assign wr_alm  = bus_we && bus_addr >= AD_ALM0 && bus_addr <= AD_ALMN;
   assign snap    = wr_ctrl && bus_wdata[CB_SNAP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         h12_q <= 1'b0;
         ien_q <= 4'h0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[CB_RUN];
            h12_q <= bus_wdata[CB_H12];
         end
         if (wr_ien) ien_q <= bus_wdata[3:0];
      end
   end

   // ---------------- calendar counters ----------------
   logic [NFLD-1:0][7:0] cur, nxt, hi, shadow;
   logic [NFLD-1:0]      at_hi, fstep, fload;
   logic st_sec, st_min, st_hr, st_day, st_mon, st_yr;

   assign st_sec = tick_p & run_q;
   assign st_min = st_sec & at_hi[F_SEC];
   assign st_hr  = st_min & at_hi[F_MIN];
   assign st_day = st_hr  & at_hi[F_HOUR];
   assign st_mon = st_day & at_hi[F_DAY];
   assign st_yr  = st_mon & at_hi[F_MON];
   assign fstep  = {st_day, st_yr, st_mon, st_day, st_hr, st_min, st_sec};

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      if (i == F_DAY) begin : g_hi_var
         assign hi[i] = last_day(cur[F_MON], cur[F_YEAR]);
      end else begin : g_hi_fix
         assign hi[i] = fld_max(i);
      end

      assign fload[i] = bus_we && !run_q && bus_addr == ADDR_W'(i);

      bcd_clk_field #(
         .LO   (fld_lo(i)),
         .MAXV (fld_max(i)),
         .RST  (fld_lo(i))
      ) u_fld (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (fstep[i]),
         .load     (fload[i]),
         .load_val (bus_wdata),
         .hi       (hi[i]),
         .cur      (cur[i]),
         .nxt      (nxt[i]),
         .at_hi    (at_hi[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    shadow[i] <= fld_lo(i);
         else if (snap) shadow[i] <= cur[i];
      end
   end

   // ---------------- alarm ----------------
   logic [NALM-1:0][7:0] alm;
   logic                 alm_hit;
   logic [2:0]           alm_idx;

   assign alm_idx = 3'(bus_addr - AD_ALM0);

   bcd_clk_alarm #(.N(NALM)) u_alarm (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_alm),
      .idx   (alm_idx),
      .wdata (bus_wdata),
      .step  (st_sec),
      .nxt   (nxt[NALM-1:0]),
      .alm   (alm),
      .hit   (alm_hit)
   );

   // ---------------- status and interrupt ----------------
   logic [7:0] status;

   bcd_clk_status #(.SEL_W(2)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .ev_set    ({st_day, st_hr, st_min, st_sec}),
      .alarm_set (alm_hit),
      .clr_en    (wr_stat),
      .clr_mask  (bus_wdata[7:2]),
      .ien       (ien_q),
      .status    (status),
      .irq       (irq)
   );

   // ---------------- read path ----------------
   always_comb begin
      bus_rdata = 8'h00;
      if (bus_addr < AD_TEND)
         bus_rdata = shadow[bus_addr[2:0]];
      else if (bus_addr <= AD_ALMN)
         bus_rdata = alm[alm_idx];
      else if (bus_addr == AD_CTRL)
         bus_rdata = {4'b0, h12_q, 2'b0, run_q};
      else if (bus_addr == AD_STAT)
         bus_rdata = status;
      else if (bus_addr == AD_IEN)
         bus_rdata = {4'b0, ien_q};
   end

   assert_frozen_when_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !bus_we) |=> $stable(cur));

   assert_snapshot_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (shadow == $past(cur)));

   assert_year_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_yr && at_hi[F_YEAR]) |=> (cur[F_YEAR] == 8'h00));

   assert_week_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_day && at_hi[F_WEEK]) |=> (cur[F_WEEK] == 8'h00));

endmodule

// File: tb/bcd_alarm_clock_test.sv
module bcd_alarm_clock_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bcd_alarm_clock uut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
   );

   // model state
   int cs, cm, ch, cd, cmo, cy, cw;
   bit run_m, al_m, pw_m;
   logic [3:0] ev_m, ie_m;
   logic [7:0] am [6];

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) << 4) + (v % 10));
   endfunction

   function automatic int mlen(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic void adv(inout int s, m, h, d, mo, y, w, inout logic [3:0] e);
      e[0] = 1'b1;
      s++;
      if (s == 60) begin
         s = 0; e[1] = 1'b1; m++;
         if (m == 60) begin
            m = 0; e[2] = 1'b1; h++;
            if (h == 24) begin
               h = 0; e[3] = 1'b1; w = (w + 1) % 7; d++;
               if (d > mlen(mo, y)) begin
                  d = 1; mo++;
                  if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
               end
            end
         end
      end
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk);
      bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = 5'(a);
      #1 d = bus_rdata;
   endtask

   task automatic tick();
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
      if (run_m) begin
         adv(cs, cm, ch, cd, cmo, cy, cw, ev_m);
         if (bcd(cs) == am[0] && bcd(cm) == am[1] && bcd(ch) == am[2] &&
             bcd(cd) == am[3] && bcd(cmo) == am[4] && bcd(cy) == am[5])
            al_m = 1'b1;
      end
   endtask

   task automatic set_run(bit r);
      wr(13, {7'b0, r}); run_m = r;
   endtask

   task automatic load_time(int s, int m, int h, int d, int mo, int y, int w);
      set_run(0);
      wr(0, bcd(s)); wr(1, bcd(m)); wr(2, bcd(h)); wr(3, bcd(d));
      wr(4, bcd(mo)); wr(5, bcd(y)); wr(6, bcd(w));
      cs = s; cm = m; ch = h; cd = d; cmo = mo; cy = y; cw = w;
   endtask

   task automatic check_time(string tag);
      logic [7:0] v;
      wr(13, {1'b0, 1'b1, 5'b0, run_m});
      rd(0, v); chk({tag, " sec"}, v, bcd(cs));
      rd(1, v); chk({tag, " min"}, v, bcd(cm));
      rd(2, v); chk({tag, " hour"}, v, bcd(ch));
      rd(3, v); chk({tag, " day"}, v, bcd(cd));
      rd(4, v); chk({tag, " month"}, v, bcd(cmo));
      rd(5, v); chk({tag, " year"}, v, bcd(cy));
      rd(6, v); chk({tag, " week"}, v, bcd(cw));
   endtask

   task automatic check_status(string tag);
      logic [7:0] v;
      logic exp_irq;
      rd(14, v);
      chk({tag, " status"}, v, {pw_m, al_m, ev_m, run_m, 1'b0});
      exp_irq = (ie_m[3] & al_m) | (ie_m[2] & ev_m[ie_m[1:0]]);
      chk({tag, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
   endtask

   task automatic clear_status();
      wr(14, 8'hFC); ev_m = '0; al_m = 0; pw_m = 0;
   endtask

   task automatic set_ie(logic [3:0] v);
      wr(15, {4'b0, v}); ie_m = v;
   endtask

   task automatic set_alarm(int s, int m, int h, int d, int mo, int y);
      am[0] = bcd(s); am[1] = bcd(m); am[2] = bcd(h);
      am[3] = bcd(d); am[4] = bcd(mo); am[5] = bcd(y);
      for (int i = 0; i < 6; i++) wr(7 + i, am[i]);
   endtask

   task automatic alarm_ahead(int k);
      int s = cs, m = cm, h = ch, d = cd, mo = cmo, y = cy, w = cw;
      logic [3:0] e = '0;
      for (int i = 0; i < k; i++) adv(s, m, h, d, mo, y, w, e);
      set_alarm(s, m, h, d, mo, y);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'd20240611));
      cs = 0; cm = 0; ch = 0; cd = 1; cmo = 1; cy = 0; cw = 0;
      run_m = 0; al_m = 0; pw_m = 1; ev_m = '0; ie_m = '0;
      for (int i = 0; i < 6; i++) am[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state (shadow reads need no snapshot)
      rd(0, v); chk("R1 sec", v, 8'h00);
      rd(3, v); chk("R1 day", v, 8'h01);
      rd(4, v); chk("R1 month", v, 8'h01);
      rd(13, v); chk("R1 ctrl", v, 8'h00);
      rd(15, v); chk("R1 ien", v, 8'h00);
      check_status("R1");
      check_time("R1");

      // R7 writing zero keeps power-up flag, writing one clears it
      wr(14, 8'h00); check_status("R7 w0");
      wr(14, 8'h80); pw_m = 0; check_status("R7 w1");

      // R4 ticks ignored while halted
      tick(); tick(); check_time("R4 halted"); check_status("R4 halted");

      // R4 invalid BCD load ignored, valid one taken
      wr(0, 8'h5A); check_time("R4 bad bcd");
      wr(0, 8'h60); check_time("R4 out of range");
      load_time(45, 0, 0, 1, 1, 0, 0); check_time("R4 load");

      // R5 snapshot bit reads back 0, bits 0 and 3 stored
      wr(13, 8'h48); rd(13, v); chk("R5 ctrl readback", v, 8'h08);
      wr(13, 8'h00);

      // R2/R6 full rollover at end of century
      clear_status();
      load_time(58, 59, 23, 31, 12, 99, 6);
      set_run(1);
      tick(); tick(); tick();
      check_time("R2 century");
      check_status("R6 all events");
      clear_status(); check_status("R7 cleared");

      // R4 writes ignored while running
      wr(0, 8'h33); wr(5, 8'h42); check_time("R4 running write");

      // R3 month-end cases
      load_time(59, 59, 23, 28, 2, 24, 3); set_run(1); tick(); check_time("R3 leap feb");
      load_time(59, 59, 23, 29, 2, 24, 3); set_run(1); tick(); check_time("R3 leap end");
      load_time(59, 59, 23, 28, 2, 23, 3); set_run(1); tick(); check_time("R3 plain feb");
      load_time(59, 59, 23, 30, 4, 10, 0); set_run(1); tick(); check_time("R3 april");
      load_time(59, 59, 23, 30, 1, 10, 0); set_run(1); tick(); check_time("R3 january");
      clear_status();

      // R8/R9 alarm with level interrupt
      load_time(50, 10, 7, 15, 6, 31, 2);
      set_ie(4'h8);
      alarm_ahead(5);
      rd(9, v); chk("R8 alarm readback", v, am[2]);
      set_run(1);
      repeat (4) tick();
      check_status("R8 before match");
      tick(); check_status("R8 match");
      tick(); check_status("R9 level held");
      clear_status(); check_status("R9 released");

      // R9 periodic selector
      for (int sel = 0; sel < 4; sel++) begin
         load_time(59, 59, 22, 10, 3, 5, 1);
         clear_status();
         set_ie(4'(4 + sel));
         set_run(1);
         tick();
         check_status("R9 periodic");
      end
      set_ie(4'h0);

      // R10 unmapped addresses
      rd(16, v); chk("R10 read", v, 8'h00);
      wr(31, 8'hFF); rd(13, v); chk("R10 write", v, {4'b0, 3'b0, run_m});

      // random trials
      for (int it = 0; it < 25; it++) begin
         int mo = $urandom_range(1, 12);
         int y  = $urandom_range(0, 99);
         int n  = $urandom_range(1, 120);
         load_time($urandom_range(0, 59), $urandom_range(0, 59), $urandom_range(0, 23),
                   $urandom_range(1, mlen(mo, y)), mo, y, $urandom_range(0, 6));
         clear_status();
         set_ie(4'($urandom_range(0, 15)));
         if ($urandom_range(0, 1) == 1) alarm_ahead($urandom_range(1, n));
         else set_alarm($urandom_range(0, 59), $urandom_range(0, 59), $urandom_range(0, 23),
                        $urandom_range(1, 28), $urandom_range(1, 12), $urandom_range(0, 99));
         set_run(1);
         for (int t = 0; t < n; t++) tick();
         check_time("R2 random");
         check_status("R9 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule